// File: doc/BRIEF.md
# Word-Select Paced Serial Audio Transmitter

This block sends one held audio sample per word period as a serial bit stream, in the slave-mode I2S style. It generates no clock of its own. An external bit clock and an external word-select line both arrive asynchronously. Both are resynchronised into the system clock domain, and the block works on their edges there. For this to be reliable, the system clock must run at no less than twice the bit-clock rate. The fastest bit clock expected is 5 MHz and the fastest word-select rate is 50 kHz.

A decoder upstream writes left and right samples into two hold registers through separate load strobes. On the first falling bit-clock edge after word select toggles, the block copies the sample of the newly selected channel into a shift register and drives its most significant bit. On each later falling edge it drives the next lower bit. Once all sample bits have gone out, it drives zeros for the rest of the word. An enable input acts as a data-valid gate on the serial output. While the enable is low the output reads zero, but shifting continues underneath.

Top module: `ws_serial_tx`

## Requirements
- R1: Word select high sends the right-channel hold register and word select low sends the left-channel hold register.
- R2: The serial output changes only after a falling edge of the bit clock. It holds its value through the whole bit-clock period.
- R3: On the first falling bit-clock edge after any word-select change, the output carries bit WIDTH-1 (the MSB) of the newly selected sample. Each following falling edge carries the next lower bit.
- R4: In a word period with more than WIDTH falling edges, every bit after the WIDTH-th is driven as 0.
- R5: While out_en is low, sdata reads 0. Bit sequencing continues regardless, so when out_en rises mid-word, the bit at the current position appears.
- R6: A load strobe captures its channel's input into the hold register. A load that arrives while a word is being sent does not change that word. The new value appears in the next word of that channel.
- R7: A word period shorter than WIDTH bits is cut short without harm. The next word-select change starts a fresh word at its MSB.
- R8: After reset, sdata is 0 and both hold registers are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| left_sample | input | WIDTH | Left-channel sample from the decoder |
| left_load | input | 1 | Capture left_sample into the left hold register |
| right_sample | input | WIDTH | Right-channel sample from the decoder |
| right_load | input | 1 | Capture right_sample into the right hold register |
| sclk | input | 1 | External bit clock, asynchronous |
| ws | input | 1 | External word select, asynchronous; high selects right |
| out_en | input | 1 | Output enable; low forces sdata to 0 |
| sdata | output | 1 | Serial data, MSB first |

## Verification
A word start and a hold-register load can fall in the same system clock cycle. In that cycle the shift register copies the old held value while the hold register takes the new one. The bench provokes this by pulsing the left load strobe exactly on the cycle in which the synchronised falling edge after a word-select change is acted upon. It then checks that this word carries the old sample and that the next left word carries the new sample.

// File: rtl/ws_serial_tx.sv
module ws_serial_tx #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] left_sample,
  input  logic             left_load,
  input  logic [WIDTH-1:0] right_sample,
  input  logic             right_load,
  input  logic             sclk,
  input  logic             ws,
  input  logic             out_en,
  output logic             sdata
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH);

  logic [2:0]       sclk_q;
  logic [1:0]       ws_q;
  logic             ws_word;
  logic [WIDTH-1:0] left_hold, right_hold, shreg;
  logic [CW-1:0]    cnt;
  logic             bit_q;

  wire fall     = sclk_q[2] & ~sclk_q[1];
  wire ws_s     = ws_q[1];
  wire new_word = ws_s != ws_word;
  wire [WIDTH-1:0] sel = ws_s ? right_hold : left_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      ws_q   <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      ws_q   <= {ws_q[0], ws};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_hold  <= '0;
      right_hold <= '0;
    end else begin
      if (left_load)  left_hold  <= left_sample;
      if (right_load) right_hold <= right_sample;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_word <= 1'b0;
      shreg   <= '0;
      cnt     <= LAST;
      bit_q   <= 1'b0;
    end else if (fall) begin
      if (new_word) begin
        ws_word <= ws_s;
        bit_q   <= sel[WIDTH-1];
        shreg   <= {sel[WIDTH-2:0], 1'b0};
        cnt     <= CW'(1);
      end else if (cnt < LAST) begin
        bit_q <= shreg[WIDTH-1];
        shreg <= {shreg[WIDTH-2:0], 1'b0};
        cnt   <= cnt + CW'(1);
      end else begin
        bit_q <= 1'b0;
      end
    end
  end

  assign sdata = out_en & bit_q;

  AST_HOLD_ON_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(bit_q)); // R2
  AST_WORD_START: assert property (@(posedge clk) disable iff (!rst_n)
    fall && new_word |=> cnt == CW'(1) && ws_word == $past(ws_s)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R4
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fall && !new_word && cnt == LAST |=> !bit_q); // R4
  AST_LEFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !left_load |=> $stable(left_hold)); // R6
  AST_RIGHT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !right_load |=> $stable(right_hold)); // R6
endmodule

// File: tb/test_ws_serial_tx.sv
module test_ws_serial_tx;
  localparam int W = 24;
  logic clk = 0, rst_n = 0;
  logic [W-1:0] left_sample = '0, right_sample = '0;
  logic left_load = 0, right_load = 0, sclk = 1, ws = 0, out_en = 1;
  logic sdata;
  int runs = 0, fails = 0;

  always #5 clk = ~clk;

  ws_serial_tx #(.WIDTH(W)) i_ws_serial_tx (
    .clk(clk), .rst_n(rst_n),
    .left_sample(left_sample), .left_load(left_load),
    .right_sample(right_sample), .right_load(right_load),
    .sclk(sclk), .ws(ws), .out_en(out_en), .sdata(sdata));

  // {ws, left, right, bits in word}
  localparam logic [54:0] VEC [6] = '{
    {1'b1, 24'h123456, 24'hA5C3F0, 6'd24},
    {1'b0, 24'h800001, 24'h000000, 6'd24},
    {1'b1, 24'h0F0F0F, 24'hFFFFFF, 6'd32},
    {1'b0, 24'hC0FFEE, 24'h7E57A1, 6'd20},
    {1'b1, 24'h000000, 24'h96E1B3, 6'd26},
    {1'b0, 24'h5A5A5A, 24'h111111, 6'd24}
  };

  task automatic check(input logic got, input logic exp, input string tag);
    runs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: sdata=%0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic do_bit(input logic exp, input string tag);
    sclk = 0;
    repeat (4) @(negedge clk);
    check(sdata, exp, tag);
    sclk = 1;
    repeat (4) @(negedge clk);
    check(sdata, exp, {tag, " R2 hold"});
  endtask

  task automatic send_bits(input logic [W-1:0] d, input int from, input int to,
                           input int en_off, input string tag);
    for (int k = from; k < to; k++) begin
      logic e;
      out_en = (k >= en_off);
      e = (k < W) ? d[W-1-k] : 1'b0;
      do_bit(e & out_en, tag);
    end
    out_en = 1;
  endtask

  task automatic start_word(input logic w);
    ws = w;
    @(negedge clk);
  endtask

  task automatic load(input logic right, input logic [W-1:0] v);
    if (right) begin right_sample = v; right_load = 1; end
    else begin left_sample = v; left_load = 1; end
    @(negedge clk);
    right_load = 0; left_load = 0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(sdata, 1'b0, "R8 reset output");
    rst_n = 1;
    repeat (3) @(negedge clk);
    do_bit(1'b0, "R8 idle after reset");

    // R1 R3 R4 R7: table of words
    for (int v = 0; v < 6; v++) begin
      logic [W-1:0] l, r;
      l = VEC[v][53:30];
      r = VEC[v][29:6];
      load(1'b0, l);
      load(1'b1, r);
      start_word(VEC[v][54]);
      send_bits(VEC[v][54] ? r : l, 0, int'(VEC[v][5:0]), 0,
                VEC[v][54] ? "R1 R3 R4 R7 right word" : "R1 R3 R4 R7 left word");
    end

    // R5: enable low for first 10 bits, shifting continues
    load(1'b1, 24'hF3CA5E);
    start_word(1'b1);
    send_bits(24'hF3CA5E, 0, 26, 10, "R5 enable gate");

    // R6: mid-word load does not disturb the current word
    load(1'b0, 24'hABCDEF);
    start_word(1'b0);
    send_bits(24'hABCDEF, 0, 10, 0, "R6 before mid load");
    load(1'b0, 24'h13579B);
    send_bits(24'hABCDEF, 10, 24, 0, "R6 after mid load");
    start_word(1'b1);
    send_bits(24'hF3CA5E, 0, 24, 0, "R6 right unchanged");
    start_word(1'b0);
    send_bits(24'h13579B, 0, 24, 0, "R6 new left value");

    // Coincident word start and load
    start_word(1'b1);
    send_bits(24'hF3CA5E, 0, 24, 0, "R1 right word");
    load(1'b0, 24'h6D2C91);
    ws = 0;
    @(negedge clk);
    sclk = 0;
    @(negedge clk);
    @(negedge clk);
    left_sample = 24'h0B0B0B;
    left_load = 1;
    @(negedge clk);
    left_load = 0;
    @(negedge clk);
    check(sdata, 1'b0, "R6 coincident load MSB old value");
    @(negedge clk);
    sclk = 1;
    repeat (4) @(negedge clk);
    send_bits(24'h6D2C91, 1, 24, 0, "R6 coincident load old word");
    start_word(1'b1);
    send_bits(24'hF3CA5E, 0, 24, 0, "R1 right word");
    start_word(1'b0);
    send_bits(24'h0B0B0B, 0, 24, 0, "R6 coincident load next word");

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule